// File: doc/BRIEF.md
# SDRAM Power-Up Bring-Up Sequencer

This block sits on the controller side of an SDRAM interface and takes the memory from power-up to its operational idle state. It waits for a clock-stable indication, lets a programmable stabilization interval run out with only NOP on the command bus, and then issues a fixed series of four commands: one precharge covering every bank, two auto-refresh commands, and a mode-register load that carries a supplied configuration word on the address lines.

Programmable NOP gaps follow each command. They cover the precharge recovery, the refresh cycle time and the settling time after the mode load. When the last gap has elapsed the block raises a ready flag. The ready flag stays high until reset, and after that point the memory controller proper takes over. If the clock-stable indication drops at any time before ready, the block abandons the partial sequence and starts again from the stabilization interval.

The command bus carries four active-low strobes, ordered chip select, row strobe, column strobe and write enable. All timing parameters are given in clock cycles and must be at least 1.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, the outputs are cmd_o = NOP, ready_o = 0, addr_o = 0 and bank_o = 0. The sequence does not advance while reset is held, whatever clk_stable_i does.
- R2: cmd_o = {cs_n, ras_n, cas_n, we_n} only ever takes these values: NOP = 4'b0111, PRECHARGE = 4'b0010, AUTO REFRESH = 4'b0001 and LOAD MODE = 4'b0000.
- R3: Suppose clk_stable_i is first sampled high at clock edge k while the block is waiting. Then NOP is driven for STAB_CYC further cycles, and PRECHARGE appears in the cycle that follows edge k+STAB_CYC.
- R4: The PRECHARGE command drives addr_o = 12'h400, meaning bit 10 set to select all banks, and bank_o = 0.
- R5: Exactly two AUTO REFRESH commands follow the precharge. The first comes PRE_GAP+1 cycles after PRECHARGE, and the second comes REF_GAP+1 cycles after the first.
- R6: LOAD MODE comes REF_GAP+1 cycles after the second refresh. It drives addr_o[9:0] = mode_word_i[9:0] and addr_o[11:10] = 2'b00 whatever the input bits 11:10 are, with bank_o = 0.
- R7: ready_o rises MRD_GAP+1 cycles after LOAD MODE. From then on it stays high and cmd_o stays NOP, including when clk_stable_i drops.
- R8: If clk_stable_i is low in any cycle before ready, the next cycle shows NOP with ready_o low, and the bring-up restarts. The next command is PRECHARGE, and it follows R3 counted from the re-assertion.
- R9: NOP is driven in every cycle apart from the four single-cycle command cycles. No command is ever repeated in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clk_stable_i | input | 1 | High when power and clock are stable |
| mode_word_i | input | 12 | Mode-register value placed on the address lines during LOAD MODE |
| cmd_o | output | 4 | {cs_n, ras_n, cas_n, we_n} command strobes |
| addr_o | output | 12 | SDRAM address lines |
| bank_o | output | 2 | SDRAM bank select |
| ready_o | output | 1 | Bring-up complete, held until reset |

## Verification
Every output is decoded from registered state, so a result shows up in the cycle after the clock edge that caused it. The bench drives its inputs and samples the outputs on the falling edge. It counts falling-edge samples from the one where a stimulus was applied: PRECHARGE is due at sample STAB_CYC+1, and each later command, and finally ready, is due at the preceding gap plus one. Restart checks drop the clock-stable input for one sample, then raise it again and count forward from that sample. The sticky-ready check watches the outputs over several samples after the drop.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

    localparam int ADDR_W  = 12;
    localparam int BANK_W  = 2;
    localparam int AP_BIT  = 10;   // address bit selecting all banks on precharge
    localparam int MODE_HI = 10;   // mode word bits at and above this are forced low

    typedef enum logic [3:0] {
        CMD_NOP  = 4'b0111,
        CMD_PRE  = 4'b0010,
        CMD_REF  = 4'b0001,
        CMD_LMR  = 4'b0000
    } cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_STAB,
        ST_PRE,
        ST_W_PRE,
        ST_REF1,
        ST_W_REF1,
        ST_REF2,
        ST_W_REF2,
        ST_LMR,
        ST_W_LMR,
        ST_READY
    } boot_state_e;

    typedef struct packed {
        cmd_e                cmd;
        logic [ADDR_W-1:0]   addr;
        logic [BANK_W-1:0]   bank;
        logic                ready;
    } boot_bus_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [ADDR_W-1:0] clean_mode(input logic [ADDR_W-1:0] w);
        logic [ADDR_W-1:0] r;
        r = w;
        for (int i = MODE_HI; i < ADDR_W; i++) r[i] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/boot_timer.sv
module boot_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] value_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load_i)        cnt_q <= value_i;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/boot_fsm.sv
module boot_fsm
    import sdram_boot_pkg::*;
#(
    parameter int STAB_CYC = 20000,
    parameter int PRE_GAP  = 3,
    parameter int REF_GAP  = 13,
    parameter int MRD_GAP  = 2,
    parameter int CNT_W    = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_stable_i,
    input  logic             tmr_zero_i,
    output logic             tmr_load_o,
    output logic [CNT_W-1:0] tmr_value_o,
    output boot_state_e      state_o
);
    localparam logic [CNT_W-1:0] STAB_LD = CNT_W'(STAB_CYC - 1);
    localparam logic [CNT_W-1:0] PRE_LD  = CNT_W'(PRE_GAP - 1);
    localparam logic [CNT_W-1:0] REF_LD  = CNT_W'(REF_GAP - 1);
    localparam logic [CNT_W-1:0] MRD_LD  = CNT_W'(MRD_GAP - 1);

    boot_state_e state_q, state_d;

    always_comb begin
        state_d     = state_q;
        tmr_load_o  = 1'b0;
        tmr_value_o = '0;
        if (!clk_stable_i && state_q != ST_READY) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    tmr_load_o  = 1'b1;
                    tmr_value_o = STAB_LD;
                    state_d     = ST_STAB;
                end
                ST_STAB:   if (tmr_zero_i) state_d = ST_PRE;
                ST_PRE: begin
                    tmr_load_o  = 1'b1;
                    tmr_value_o = PRE_LD;
                    state_d     = ST_W_PRE;
                end
                ST_W_PRE:  if (tmr_zero_i) state_d = ST_REF1;
                ST_REF1: begin
                    tmr_load_o  = 1'b1;
                    tmr_value_o = REF_LD;
                    state_d     = ST_W_REF1;
                end
                ST_W_REF1: if (tmr_zero_i) state_d = ST_REF2;
                ST_REF2: begin
                    tmr_load_o  = 1'b1;
                    tmr_value_o = REF_LD;
                    state_d     = ST_W_REF2;
                end
                ST_W_REF2: if (tmr_zero_i) state_d = ST_LMR;
                ST_LMR: begin
                    tmr_load_o  = 1'b1;
                    tmr_value_o = MRD_LD;
                    state_d     = ST_W_LMR;
                end
                ST_W_LMR:  if (tmr_zero_i) state_d = ST_READY;
                ST_READY:  state_d = ST_READY;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/boot_cmd_enc.sv
module boot_cmd_enc
    import sdram_boot_pkg::*;
(
    input  boot_state_e        state_i,
    input  logic [ADDR_W-1:0]  mode_word_i,
    output boot_bus_t          bus_o
);
    localparam logic [ADDR_W-1:0] PRE_ADDR = ADDR_W'(1) << AP_BIT;

    always_comb begin
        bus_o       = '{cmd: CMD_NOP, addr: '0, bank: '0, ready: 1'b0};
        unique case (state_i)
            ST_PRE: begin
                bus_o.cmd  = CMD_PRE;
                bus_o.addr = PRE_ADDR;
            end
            ST_REF1, ST_REF2: bus_o.cmd = CMD_REF;
            ST_LMR: begin
                bus_o.cmd  = CMD_LMR;
                bus_o.addr = clean_mode(mode_word_i);
            end
            ST_READY: bus_o.ready = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
    import sdram_boot_pkg::*;
#(
    parameter int STAB_CYC = 20000,
    parameter int PRE_GAP  = 3,
    parameter int REF_GAP  = 13,
    parameter int MRD_GAP  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_stable_i,
    input  logic [ADDR_W-1:0] mode_word_i,
    output logic [3:0]        cmd_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BANK_W-1:0] bank_o,
    output logic              ready_o
);
    localparam int MAX_LD = max_of(max_of(STAB_CYC, PRE_GAP), max_of(REF_GAP, MRD_GAP));
    localparam int CNT_W  = $clog2(MAX_LD + 1);

    logic             tmr_load, tmr_zero;
    logic [CNT_W-1:0] tmr_value;
    boot_state_e      state;
    boot_bus_t        bus;

    boot_timer #(.CNT_W(CNT_W)) timer_i (
        .clk     (clk),
        .rst     (rst),
        .load_i  (tmr_load),
        .value_i (tmr_value),
        .zero_o  (tmr_zero)
    );

    boot_fsm #(
        .STAB_CYC (STAB_CYC),
        .PRE_GAP  (PRE_GAP),
        .REF_GAP  (REF_GAP),
        .MRD_GAP  (MRD_GAP),
        .CNT_W    (CNT_W)
    ) fsm_i (
        .clk          (clk),
        .rst          (rst),
        .clk_stable_i (clk_stable_i),
        .tmr_zero_i   (tmr_zero),
        .tmr_load_o   (tmr_load),
        .tmr_value_o  (tmr_value),
        .state_o      (state)
    );

    boot_cmd_enc enc_i (
        .state_i     (state),
        .mode_word_i (mode_word_i),
        .bus_o       (bus)
    );

    assign cmd_o   = bus.cmd;
    assign addr_o  = bus.addr;
    assign bank_o  = bus.bank;
    assign ready_o = bus.ready;
endmodule

// File: rtl/sdram_boot_seq_chk.sv
module sdram_boot_seq_chk
    import sdram_boot_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              clk_stable_i,
    input logic [ADDR_W-1:0] mode_word_i,
    input logic [3:0]        cmd_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic [BANK_W-1:0] bank_o,
    input logic              ready_o
);
    logic       pre_seen;
    logic [1:0] ref_seen;

    always_ff @(posedge clk) begin
        if (rst || (!clk_stable_i && !ready_o)) begin
            pre_seen <= 1'b0;
            ref_seen <= '0;
        end else if (cmd_o == CMD_PRE) begin
            pre_seen <= 1'b1;
            ref_seen <= '0;
        end else if (cmd_o == CMD_REF && ref_seen != 2'd3) begin
            ref_seen <= ref_seen + 2'd1;
        end
    end

    assert_legal_cmd_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_o inside {CMD_NOP, CMD_PRE, CMD_REF, CMD_LMR});

    assert_pre_all_banks_R4: assert property (@(posedge clk) disable iff (rst)
        cmd_o == CMD_PRE |-> addr_o[AP_BIT] && bank_o == '0);

    assert_ref_order_R5: assert property (@(posedge clk) disable iff (rst)
        cmd_o == CMD_REF |-> pre_seen && ref_seen < 2'd2);

    assert_lmr_order_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_o == CMD_LMR |-> pre_seen && ref_seen == 2'd2);

    assert_lmr_word_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_o == CMD_LMR |-> addr_o[ADDR_W-1:MODE_HI] == '0 &&
                              addr_o[MODE_HI-1:0] == mode_word_i[MODE_HI-1:0]);

    assert_ready_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ready_o |=> ready_o);

    assert_ready_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> cmd_o == CMD_NOP);

    assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (!clk_stable_i && !ready_o) |=> (cmd_o == CMD_NOP && !ready_o));

    assert_single_cmd_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_o != CMD_NOP |=> cmd_o == CMD_NOP);
endmodule

bind sdram_boot_seq sdram_boot_seq_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .clk_stable_i (clk_stable_i),
    .mode_word_i  (mode_word_i),
    .cmd_o        (cmd_o),
    .addr_o       (addr_o),
    .bank_o       (bank_o),
    .ready_o      (ready_o)
);

// File: tb/sdram_boot_seq_tb_top.sv
module sdram_boot_seq_tb_top;
    import sdram_boot_pkg::*;

    localparam int STAB = 40;
    localparam int PG   = 3;
    localparam int RG   = 9;
    localparam int MG   = 2;
    localparam int LIM  = 4 * STAB;

    localparam logic [3:0] NOP = 4'b0111;
    localparam logic [3:0] PRE = 4'b0010;
    localparam logic [3:0] REF = 4'b0001;
    localparam logic [3:0] LMR = 4'b0000;

    typedef struct packed {
        logic [11:0] mode;
        logic [11:0] exp_addr;
    } vec_t;

    localparam vec_t VECS [3] = '{
        '{mode: 12'h032, exp_addr: 12'h032},
        '{mode: 12'hC27, exp_addr: 12'h027},
        '{mode: 12'h23B, exp_addr: 12'h23B}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stable = 1'b0;
    logic [11:0] mode = '0;
    logic [3:0]  cmd;
    logic [11:0] addr;
    logic [1:0]  bank;
    logic        ready;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sdram_boot_seq #(
        .STAB_CYC (STAB),
        .PRE_GAP  (PG),
        .REF_GAP  (RG),
        .MRD_GAP  (MG)
    ) dut_i (
        .clk          (clk),
        .rst          (rst),
        .clk_stable_i (stable),
        .mode_word_i  (mode),
        .cmd_o        (cmd),
        .addr_o       (addr),
        .bank_o       (bank),
        .ready_o      (ready)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Counts samples until a non-NOP command or ready appears.
    task automatic wait_event(output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (cmd == NOP && !ready && n < LIM);
    endtask

    task automatic do_reset();
        rst    = 1'b1;
        stable = 1'b0;
        repeat (3) step();
    endtask

    // From a sample point with stable just raised, walks the whole sequence.
    task automatic walk_sequence(input logic [11:0] exp_addr);
        int n;
        wait_event(n);
        check(cmd == PRE, "R3 first cmd", cmd, PRE);
        check(n == STAB + 1, "R3 delay", n, STAB + 1);
        check(addr == 12'h400 && bank == 2'd0, "R4 precharge addr", addr, 12'h400);
        wait_event(n);
        check(cmd == REF && n == PG + 1, "R5 first refresh", n, PG + 1);
        wait_event(n);
        check(cmd == REF && n == RG + 1, "R5 second refresh", n, RG + 1);
        wait_event(n);
        check(cmd == LMR && n == RG + 1, "R6 mode load timing", n, RG + 1);
        check(addr == exp_addr && bank == 2'd0, "R6 mode word", addr, exp_addr);
        wait_event(n);
        check(ready && cmd == NOP, "R9 no extra command", cmd, NOP);
        check(n == MG + 1, "R7 ready timing", n, MG + 1);
    endtask

    initial begin
        int n;
        // R1: reset state, and no progress while reset is held
        do_reset();
        stable = 1'b1;
        check(cmd == NOP && !ready && addr == 0 && bank == 0, "R1 reset outputs", cmd, NOP);
        n = 0;
        for (int i = 0; i < STAB + 5; i++) begin
            step();
            if (cmd != NOP || ready) n++;
        end
        check(n == 0, "R1 held in reset", n, 0);

        // Table walk: full sequence for each mode word (R3..R7, R9)
        foreach (VECS[i]) begin
            do_reset();
            mode   = VECS[i].mode;
            rst    = 1'b0;
            stable = 1'b1;
            check(cmd == NOP && !ready, "R1 first cycle after reset", cmd, NOP);
            walk_sequence(VECS[i].exp_addr);
        end

        // R7: ready ignores clk_stable drop and holds NOP
        stable = 1'b0;
        n = 0;
        for (int i = 0; i < 6; i++) begin
            step();
            if (!ready || cmd != NOP) n++;
        end
        check(n == 0, "R7 sticky ready", n, 0);

        // R8: drop during stabilization delay
        do_reset();
        mode   = 12'h022;
        rst    = 1'b0;
        stable = 1'b1;
        repeat (STAB / 2) step();
        stable = 1'b0;
        step();
        check(cmd == NOP && !ready, "R8 drop in delay", cmd, NOP);
        stable = 1'b1;
        walk_sequence(12'h022);

        // R8: drop right after the first refresh
        do_reset();
        mode   = 12'h037;
        rst    = 1'b0;
        stable = 1'b1;
        wait_event(n);
        wait_event(n);
        check(cmd == REF, "R8 reached refresh", cmd, REF);
        stable = 1'b0;
        step();
        check(cmd == NOP && !ready, "R8 drop in refresh", cmd, NOP);
        stable = 1'b1;
        walk_sequence(12'h037);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule